// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block sits beside the fetch stage of a 32-bit core and turns one or more exception requests into a single exception entry. On the clock edge where any request bit is high, it chooses the request with the lowest exception code. It then updates the exception-level flag, the cause code, the branch-delay flag, the resume PC, the fault-address registers and the two virtual-page-pair fields. In the same edge it computes the handler address. That address leaves the block as a one-cycle redirect pulse in the following cycle.

A memory-management fault arrives as one request bit, together with a three-bit translation result and the access kind. The block maps these to the architectural code. The handler address depends on several things: the boot-vector flag, the exception-base input, whether the fault is a refill miss taken at exception level zero, whether it is a cache error, and the vectored-interrupt spacing. For vectored interrupts, the highest-numbered enabled pending line selects the vector.

The redirect output is a valid-only stream (`redirect_valid`, `redirect_pc`) with no ready. The consumer must accept the address in the cycle it is shown, because a redirect cannot be stalled. Holding a request high for several cycles produces one entry per cycle. All other pins are plain levels that are sampled on the request edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `exc_level`, `cause_bd` and `redirect_valid` are 0, and `cause_code`, `epc` and `bad_addr` are all zero.
- R2: When several request bits are high, the lowest code wins. The request bits and their codes are:

  | `exc_req` bit | Request | Code |
  |---|---|---|
  | 0 | interrupt | 0 |
  | 1 | memory fault | from R3 |
  | 2 | syscall | 8 |
  | 3 | break | 9 |
  | 4 | reserved instruction | 10 |
  | 5 | coprocessor unusable | 11 |
  | 6 | overflow | 12 |
  | 7 | trap | 13 |
  | 8 | cache error | 30 |

- R3: A memory fault takes its code from `mmu_res` and `acc_kind`. In `acc_kind`, load=0, store=1, fetch=2.

  | `mmu_res` | Result | Code |
  |---|---|---|
  | 0 | bad address | 5 on a store, otherwise 4 |
  | 1 | no match | 3 on a store, otherwise 2 |
  | 2 | invalid | 3 on a store, otherwise 2 |
  | 3 | dirty | 1 |
  | 4 | read-inhibit | 19 if `sep_inhibit_en` is high, otherwise 2 |
  | 5 | execute-inhibit | 20 if `sep_inhibit_en` is high, otherwise 2 |

  The values 6 and 7 act as bad address.
- R4: The handler base depends on `boot_vec`.
  - With `boot_vec` high, the base is BOOT_BASE + 0x200.
  - Otherwise, the base is `exc_base` with bits 11:0 cleared.
- R5: The handler offset depends on the winning exception.
  - The default offset is 0x180.
  - A no-match fault (code 2 or 3) taken while `exc_level` is 0 uses offset 0x000.
  - The same fault taken while `exc_level` is 1 uses 0x180.
  - A cache error uses offset 0x100.
- R6: A cache error with `boot_vec` low and `cache_vec_keep` low uses base 0xA0000000 | (`exc_base` & 0x1FFFF000).
- R7: An interrupt with `vec_irq_en` low uses offset 0x180. With `vec_irq_en` high, the offset depends on `boot_vec` and `irq_spacing`.
  - If `boot_vec` is high or `irq_spacing` is 0, the offset is 0x200.
  - Otherwise, the offset is 0x200 + v·(`irq_spacing`·32). Here v is the index of the highest set bit of `irq_pending` & `irq_mask`, or 0 if there is none.
- R8: Only when `exc_level` is 0 at the request does an entry load three things: `epc`, `cause_bd` (set to `in_delay_slot`) and `exc_level`=1.
  - `epc` is (`cur_pc` | `mode16`), minus 4 (or minus 2 when `mode16` is high) if `in_delay_slot` is high.
  - With `exc_level` at 1, `epc` and `cause_bd` hold.
- R9: `cause_code` is loaded with the winning code on every entry, whatever the exception level.
- R10: When the memory fault wins, the block loads three fields:
  - `bad_addr` takes `fault_addr`.
  - `ctx_vpn2` and `hi_vpn2` take `fault_addr`[31:13].

  Any other entry leaves all three unchanged.
- R11: An entry updates its state on the request edge. `redirect_valid` is high for exactly the following cycle, with `redirect_pc` valid in that cycle.
- R12: `leave_exc` high with no request clears `exc_level`. If a request is present in the same cycle, the request takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 9 | Request bits, one per source (R2) |
| mmu_res | input | 3 | Translation result for a memory fault |
| acc_kind | input | 2 | Access kind: load 0, store 1, fetch 2 |
| fault_addr | input | 32 | Faulting virtual address |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_delay_slot | input | 1 | Instruction sits in a branch delay slot |
| mode16 | input | 1 | 16-bit instruction mode |
| sep_inhibit_en | input | 1 | Give inhibit faults their own codes |
| boot_vec | input | 1 | Use the boot vector base |
| cache_vec_keep | input | 1 | Cache error keeps the normal base |
| exc_base | input | 32 | Exception base address |
| vec_irq_en | input | 1 | Vectored interrupts enabled |
| irq_spacing | input | 5 | Vector spacing in 32-byte units |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Interrupt enable mask |
| leave_exc | input | 1 | Handler return, clears the exception level |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Handler address |
| exc_level | output | 1 | Exception level flag |
| cause_code | output | 5 | Code of the last entry |
| cause_bd | output | 1 | Last recorded entry was in a delay slot |
| epc | output | 32 | Resume PC |
| bad_addr | output | 32 | Last faulting address |
| ctx_vpn2 | output | 19 | Context page-pair field (address bits 31:13) |
| hi_vpn2 | output | 19 | Entry-high page-pair field (address bits 31:13) |

## Verification
The properties take several things for granted about the inputs after reset:
- Every input is at a known level.
- Each cycle with a request bit high is a separate entry.
- BOOT_BASE and `exc_base` keep the handler word-aligned.
- `mmu_res` stays within the six defined results.

The stimulus changes inputs only at the falling clock edge and holds each request for exactly one rising edge. It keeps `exc_base`, the fault addresses and the PCs at aligned, fixed values chosen so that every expected address can be computed by hand.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int CODE_W  = 5;
  localparam int NUM_SRC = 9;

  // request source positions (priority is by resulting code, not position)
  localparam int SRC_IRQ   = 0;
  localparam int SRC_MMU   = 1;
  localparam int SRC_SYS   = 2;
  localparam int SRC_BRK   = 3;
  localparam int SRC_RSV   = 4;
  localparam int SRC_COP   = 5;
  localparam int SRC_OVF   = 6;
  localparam int SRC_TRP   = 7;
  localparam int SRC_CACHE = 8;

  typedef enum logic [2:0] {
    XL_BADADDR = 3'd0,
    XL_NOMATCH = 3'd1,
    XL_INVALID = 3'd2,
    XL_DIRTY   = 3'd3,
    XL_RDINH   = 3'd4,
    XL_XINH    = 3'd5
  } xlat_res_e;

  typedef enum logic [1:0] {
    AK_LOAD  = 2'd0,
    AK_STORE = 2'd1,
    AK_FETCH = 2'd2
  } acc_kind_e;

  localparam logic [CODE_W-1:0] EC_INT  = 5'd0;
  localparam logic [CODE_W-1:0] EC_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] EC_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] EC_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADES = 5'd5;
  localparam logic [CODE_W-1:0] EC_SYS  = 5'd8;
  localparam logic [CODE_W-1:0] EC_BRK  = 5'd9;
  localparam logic [CODE_W-1:0] EC_RSV  = 5'd10;
  localparam logic [CODE_W-1:0] EC_COP  = 5'd11;
  localparam logic [CODE_W-1:0] EC_OVF  = 5'd12;
  localparam logic [CODE_W-1:0] EC_TRP  = 5'd13;
  localparam logic [CODE_W-1:0] EC_RDI  = 5'd19;
  localparam logic [CODE_W-1:0] EC_XI   = 5'd20;
  localparam logic [CODE_W-1:0] EC_CERR = 5'd30;

  function automatic logic [CODE_W-1:0] src_fixed_code(input int src);
    case (src)
      SRC_SYS:   return EC_SYS;
      SRC_BRK:   return EC_BRK;
      SRC_RSV:   return EC_RSV;
      SRC_COP:   return EC_COP;
      SRC_OVF:   return EC_OVF;
      SRC_TRP:   return EC_TRP;
      SRC_CACHE: return EC_CERR;
      default:   return EC_INT;
    endcase
  endfunction

endpackage

// File: rtl/exc_code_sel.sv
module exc_code_sel
  import exc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic [N_SRC-1:0]  req,
  input  logic [2:0]        xres,
  input  logic [1:0]        akind,
  input  logic              sep_en,
  output logic              hit,
  output logic [CODE_W-1:0] win_code,
  output logic              win_mmu,
  output logic              win_irq,
  output logic              win_cache,
  output logic              tlb_miss
);

  localparam int SRC_W = $clog2(N_SRC);

  logic [CODE_W-1:0] cand [N_SRC];
  logic [CODE_W-1:0] mmu_code;
  logic [SRC_W-1:0]  win_src;
  xlat_res_e         res_e;
  logic              is_store;

  assign res_e    = xlat_res_e'(xres);
  assign is_store = (acc_kind_e'(akind) == AK_STORE);

  always_comb begin
    case (res_e)
      XL_NOMATCH, XL_INVALID: mmu_code = is_store ? EC_TLBS : EC_TLBL;
      XL_DIRTY:               mmu_code = EC_MOD;
      XL_RDINH:               mmu_code = sep_en ? EC_RDI : EC_TLBL;
      XL_XINH:                mmu_code = sep_en ? EC_XI  : EC_TLBL;
      default:                mmu_code = is_store ? EC_ADES : EC_ADEL;
    endcase
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_cand
    if (g == SRC_MMU) begin : g_mmu
      assign cand[g] = mmu_code;
    end else begin : g_fix
      assign cand[g] = src_fixed_code(g);
    end
  end

  always_comb begin
    hit      = 1'b0;
    win_code = '1;
    win_src  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!hit || cand[i] < win_code)) begin
        hit      = 1'b1;
        win_code = cand[i];
        win_src  = SRC_W'(i);
      end
    end
    if (!hit) win_code = '0;
  end

  assign win_mmu   = hit && (win_src == SRC_W'(SRC_MMU));
  assign win_irq   = hit && (win_src == SRC_W'(SRC_IRQ));
  assign win_cache = hit && (win_src == SRC_W'(SRC_CACHE));
  assign tlb_miss  = win_mmu && (res_e == XL_NOMATCH);

endmodule

// File: rtl/exc_irq_prio.sv
module exc_irq_prio #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] pending,
  input  logic [N_IRQ-1:0] mask,
  output logic [IDX_W-1:0] top_idx
);

  logic [N_IRQ-1:0] live;
  assign live = pending & mask;

  // later (higher) set bits overwrite earlier ones
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (live[i]) top_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc #(
  parameter int              XLEN      = 32,
  parameter int              SPACE_W   = 5,
  parameter int              IDX_W     = 3,
  parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0000
) (
  input  logic               boot_vec,
  input  logic               cache_keep,
  input  logic [XLEN-1:0]    ebase,
  input  logic               lvl,
  input  logic               is_irq,
  input  logic               is_cache,
  input  logic               tlb_miss,
  input  logic               vec_en,
  input  logic [SPACE_W-1:0] spacing,
  input  logic [IDX_W-1:0]   irq_idx,
  output logic [XLEN-1:0]    handler
);

  localparam logic [XLEN-1:0] OFS_REFILL = XLEN'(32'h000);
  localparam logic [XLEN-1:0] OFS_CACHE  = XLEN'(32'h100);
  localparam logic [XLEN-1:0] OFS_GEN    = XLEN'(32'h180);
  localparam logic [XLEN-1:0] OFS_IRQ    = XLEN'(32'h200);
  localparam logic [XLEN-1:0] KSEG1_WIN  = XLEN'(32'hA000_0000);
  localparam logic [XLEN-1:0] CERR_MASK  = XLEN'(32'h1FFF_F000);
  localparam logic [XLEN-1:0] PAGE_MASK  = ~XLEN'(32'hFFF);

  logic [XLEN-1:0] base, ofs, step;

  assign step = XLEN'(spacing) << 5;

  always_comb begin
    if (boot_vec)
      base = BOOT_BASE + OFS_IRQ;
    else if (is_cache && !cache_keep)
      base = KSEG1_WIN | (ebase & CERR_MASK);
    else
      base = ebase & PAGE_MASK;
  end

  always_comb begin
    if (is_cache)
      ofs = OFS_CACHE;
    else if (is_irq) begin
      if (!vec_en)
        ofs = OFS_GEN;
      else if (boot_vec || spacing == '0)
        ofs = OFS_IRQ;
      else
        ofs = OFS_IRQ + XLEN'(irq_idx) * step;
    end else if (tlb_miss && !lvl)
      ofs = OFS_REFILL;
    else
      ofs = OFS_GEN;
  end

  assign handler = base + ofs;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              N_IRQ     = 8,
  parameter int              SPACE_W   = 5,
  parameter int              PAIR_LSB  = 13,
  parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       exc_req,
  input  logic [2:0]               mmu_res,
  input  logic [1:0]               acc_kind,
  input  logic [XLEN-1:0]          fault_addr,
  input  logic [XLEN-1:0]          cur_pc,
  input  logic                     in_delay_slot,
  input  logic                     mode16,
  input  logic                     sep_inhibit_en,
  input  logic                     boot_vec,
  input  logic                     cache_vec_keep,
  input  logic [XLEN-1:0]          exc_base,
  input  logic                     vec_irq_en,
  input  logic [SPACE_W-1:0]       irq_spacing,
  input  logic [N_IRQ-1:0]         irq_pending,
  input  logic [N_IRQ-1:0]         irq_mask,
  input  logic                     leave_exc,
  output logic                     redirect_valid,
  output logic [XLEN-1:0]          redirect_pc,
  output logic                     exc_level,
  output logic [CODE_W-1:0]        cause_code,
  output logic                     cause_bd,
  output logic [XLEN-1:0]          epc,
  output logic [XLEN-1:0]          bad_addr,
  output logic [XLEN-PAIR_LSB-1:0] ctx_vpn2,
  output logic [XLEN-PAIR_LSB-1:0] hi_vpn2
);

  localparam int IDX_W  = $clog2(N_IRQ);
  localparam int PAIR_W = XLEN - PAIR_LSB;

  logic              hit, win_mmu, win_irq, win_cache, tlb_miss;
  logic [CODE_W-1:0] win_code;
  logic [IDX_W-1:0]  irq_idx;
  logic [XLEN-1:0]   handler, resume, back;

  exc_code_sel #(.N_SRC(NUM_SRC)) u_sel (
    .req       (exc_req),
    .xres      (mmu_res),
    .akind     (acc_kind),
    .sep_en    (sep_inhibit_en),
    .hit       (hit),
    .win_code  (win_code),
    .win_mmu   (win_mmu),
    .win_irq   (win_irq),
    .win_cache (win_cache),
    .tlb_miss  (tlb_miss)
  );

  exc_irq_prio #(.N_IRQ(N_IRQ)) u_prio (
    .pending (irq_pending),
    .mask    (irq_mask),
    .top_idx (irq_idx)
  );

  exc_vec_calc #(
    .XLEN      (XLEN),
    .SPACE_W   (SPACE_W),
    .IDX_W     (IDX_W),
    .BOOT_BASE (BOOT_BASE)
  ) u_vec (
    .boot_vec   (boot_vec),
    .cache_keep (cache_vec_keep),
    .ebase      (exc_base),
    .lvl        (exc_level),
    .is_irq     (win_irq),
    .is_cache   (win_cache),
    .tlb_miss   (tlb_miss),
    .vec_en     (vec_irq_en),
    .spacing    (irq_spacing),
    .irq_idx    (irq_idx),
    .handler    (handler)
  );

  // resume point: step back over the branch when in its delay slot
  assign back   = in_delay_slot ? (mode16 ? XLEN'(2) : XLEN'(4)) : '0;
  assign resume = (cur_pc | XLEN'(mode16)) - back;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      exc_level      <= 1'b0;
      cause_code     <= '0;
      cause_bd       <= 1'b0;
      epc            <= '0;
      bad_addr       <= '0;
      ctx_vpn2       <= '0;
      hi_vpn2        <= '0;
    end else begin
      redirect_valid <= hit;
      if (hit) begin
        redirect_pc <= handler;
        cause_code  <= win_code;
        if (!exc_level) begin
          epc       <= resume;
          cause_bd  <= in_delay_slot;
          exc_level <= 1'b1;
        end
        if (win_mmu) begin
          bad_addr <= fault_addr;
          ctx_vpn2 <= fault_addr[XLEN-1:PAIR_LSB];
          hi_vpn2  <= fault_addr[XLEN-1:PAIR_LSB];
        end
      end else if (leave_exc) begin
        exc_level <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SRC-1:0] exc_req,
  input logic              leave_exc,
  input logic              redirect_valid,
  input logic [XLEN-1:0]   redirect_pc,
  input logic              exc_level,
  input logic [CODE_W-1:0] cause_code,
  input logic              cause_bd,
  input logic [XLEN-1:0]   epc,
  input logic [XLEN-1:0]   bad_addr
);

  a_r11_pulse_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_req) |=> redirect_valid);

  a_r11_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|exc_req) |=> !redirect_valid);

  a_r8_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_req) |=> exc_level);

  a_r8_nested_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|exc_req) && exc_level) |=> ($stable(epc) && $stable(cause_bd)));

  a_r2_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req[SRC_IRQ] |=> (cause_code == EC_INT));

  a_r12_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_exc && !(|exc_req)) |=> !exc_level);

  a_r10_badaddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req[SRC_MMU] |=> $stable(bad_addr));

  a_r4_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc[1:0] == 2'b00));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .exc_req        (exc_req),
  .leave_exc      (leave_exc),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .exc_level      (exc_level),
  .cause_code     (cause_code),
  .cause_bd       (cause_bd),
  .epc            (epc),
  .bad_addr       (bad_addr)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  exc_req = '0;
  logic [2:0]  mmu_res = '0;
  logic [1:0]  acc_kind = '0;
  logic [31:0] fault_addr = 32'h1234_5678;
  logic [31:0] cur_pc = 32'h0040_1000;
  logic        in_delay_slot = 1'b0, mode16 = 1'b0, sep_inhibit_en = 1'b0;
  logic        boot_vec = 1'b0, cache_vec_keep = 1'b0;
  logic [31:0] exc_base = 32'h9234_5678;
  logic        vec_irq_en = 1'b0;
  logic [4:0]  irq_spacing = '0;
  logic [7:0]  irq_pending = '0, irq_mask = '0;
  logic        leave_exc = 1'b0;
  logic        redirect_valid, exc_level, cause_bd;
  logic [31:0] redirect_pc, epc, bad_addr;
  logic [4:0]  cause_code;
  logic [18:0] ctx_vpn2, hi_vpn2;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .mmu_res(mmu_res),
    .acc_kind(acc_kind), .fault_addr(fault_addr), .cur_pc(cur_pc),
    .in_delay_slot(in_delay_slot), .mode16(mode16),
    .sep_inhibit_en(sep_inhibit_en), .boot_vec(boot_vec),
    .cache_vec_keep(cache_vec_keep), .exc_base(exc_base),
    .vec_irq_en(vec_irq_en), .irq_spacing(irq_spacing),
    .irq_pending(irq_pending), .irq_mask(irq_mask), .leave_exc(leave_exc),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .exc_level(exc_level), .cause_code(cause_code), .cause_bd(cause_bd),
    .epc(epc), .bad_addr(bad_addr), .ctx_vpn2(ctx_vpn2), .hi_vpn2(hi_vpn2)
  );

  typedef struct packed {
    logic [8:0]  req;
    logic [2:0]  res;
    logic [1:0]  acc;
    logic        sep, boot, keep, ds, m16;
    logic [4:0]  code;
    logic [31:0] hpc;
    logic [31:0] repc;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{9'h004, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd8,  32'h9234_5180, 32'h0040_1000},
    '{9'h002, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  32'h9234_5000, 32'h0040_1000},
    '{9'h002, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3,  32'h9234_5000, 32'h0040_1000},
    '{9'h002, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  32'h9234_5180, 32'h0040_1000},
    '{9'h002, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  32'h9234_5180, 32'h0040_1000},
    '{9'h002, 3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd5,  32'h9234_5180, 32'h0040_1000},
    '{9'h002, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd4,  32'h9234_5180, 32'h0040_0FFC},
    '{9'h002, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  32'h9234_5180, 32'h0040_1000},
    '{9'h002, 3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd19, 32'h9234_5180, 32'h0040_1000},
    '{9'h002, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd20, 32'h9234_5180, 32'h0040_1000},
    '{9'h002, 3'd5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  32'h9234_5180, 32'h0040_1000},
    '{9'h100, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd30, 32'hB234_5100, 32'h0040_1000},
    '{9'h100, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd30, 32'h9234_5100, 32'h0040_1000},
    '{9'h100, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd30, 32'hBFC0_0300, 32'h0040_1000},
    '{9'h004, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd8,  32'hBFC0_0380, 32'h0040_1000},
    '{9'h002, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2,  32'hBFC0_0200, 32'h0040_1000},
    '{9'h088, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd9,  32'h9234_5180, 32'h0040_1000},
    '{9'h006, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd8,  32'h9234_5180, 32'h0040_1000},
    '{9'h00A, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  32'h9234_5000, 32'h0040_1000},
    '{9'h1FF, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  32'h9234_5180, 32'h0040_1000},
    '{9'h010, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd10, 32'h9234_5180, 32'h0040_0FFF},
    '{9'h020, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd11, 32'h9234_5180, 32'h0040_1001},
    '{9'h040, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd12, 32'h9234_5180, 32'h0040_0FFC},
    '{9'h080, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd13, 32'h9234_5180, 32'h0040_1000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic leave();
    @(negedge clk);
    leave_exc = 1'b1;
    @(negedge clk);
    leave_exc = 1'b0;
  endtask

  // drive at a falling edge, hold over one rising edge, sample at the next falling edge
  task automatic fire(input vec_t v);
    @(negedge clk);
    exc_req = v.req; mmu_res = v.res; acc_kind = v.acc; sep_inhibit_en = v.sep;
    boot_vec = v.boot; cache_vec_keep = v.keep; in_delay_slot = v.ds; mode16 = v.m16;
    @(negedge clk);
    exc_req = '0;
  endtask

  function automatic vec_t mk(input logic [8:0] req, input logic [2:0] res, input logic ds);
    vec_t v;
    v = '0;
    v.req = req; v.res = res; v.ds = ds;
    return v;
  endfunction

  initial begin
    #(100us);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 exc_level", {31'd0, exc_level}, 32'd0);
    check("R1 redirect_valid", {31'd0, redirect_valid}, 32'd0);
    check("R1 cause_code", {27'd0, cause_code}, 32'd0);
    check("R1 epc", epc, 32'd0);
    check("R1 cause_bd", {31'd0, cause_bd}, 32'd0);
    check("R1 bad_addr", bad_addr, 32'd0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      leave();
      fire(TBL[i]);
      check($sformatf("R2/R3 code vec%0d", i), {27'd0, cause_code}, {27'd0, TBL[i].code});
      check($sformatf("R4/R5/R6 pc vec%0d", i), redirect_pc, TBL[i].hpc);
      check($sformatf("R8 epc vec%0d", i), epc, TBL[i].repc);
      check($sformatf("R8 bd vec%0d", i), {31'd0, cause_bd}, {31'd0, TBL[i].ds});
      check($sformatf("R11 pulse vec%0d", i), {31'd0, redirect_valid}, 32'd1);
    end
    @(negedge clk);
    check("R11 pulse ends", {31'd0, redirect_valid}, 32'd0);
    check("R8 level set", {31'd0, exc_level}, 32'd1);

    // R12 leave clears level
    leave();
    check("R12 level cleared", {31'd0, exc_level}, 32'd0);

    // R8 nesting: second entry at level 1 keeps epc/bd, R5 no refill offset, R9 code still written
    fire(mk(9'h004, 3'd0, 1'b1));
    check("R8 first epc", epc, 32'h0040_0FFC);
    cur_pc = 32'h0050_0000;
    fire(mk(9'h002, 3'd1, 1'b0));
    check("R9 nested code", {27'd0, cause_code}, 32'd2);
    check("R5 nested miss offset", redirect_pc, 32'h9234_5180);
    check("R8 nested epc hold", epc, 32'h0040_0FFC);
    check("R8 nested bd hold", {31'd0, cause_bd}, 32'd1);
    check("R8 nested level", {31'd0, exc_level}, 32'd1);
    cur_pc = 32'h0040_1000;

    // R10 fault address capture and hold
    leave();
    fault_addr = 32'h1234_5678;
    fire(mk(9'h002, 3'd2, 1'b0));
    check("R10 bad_addr", bad_addr, 32'h1234_5678);
    check("R10 ctx_vpn2", {13'd0, ctx_vpn2}, 32'h0000_91A2);
    check("R10 hi_vpn2", {13'd0, hi_vpn2}, 32'h0000_91A2);
    fault_addr = 32'hFFFF_0000;
    fire(mk(9'h004, 3'd0, 1'b0));
    check("R10 bad_addr hold", bad_addr, 32'h1234_5678);
    check("R10 hi_vpn2 hold", {13'd0, hi_vpn2}, 32'h0000_91A2);

    // R7 vectored interrupts
    vec_irq_en = 1'b1; irq_spacing = 5'd1; irq_pending = 8'h26; irq_mask = 8'hF7;
    leave();
    fire(mk(9'h001, 3'd0, 1'b0));
    check("R7 vector 5 spacing 1", redirect_pc, 32'h9234_52A0);
    irq_spacing = 5'd2; irq_mask = 8'h0F;
    leave();
    fire(mk(9'h001, 3'd0, 1'b0));
    check("R7 masked vector 2 spacing 2", redirect_pc, 32'h9234_5280);
    irq_spacing = 5'd0;
    leave();
    fire(mk(9'h001, 3'd0, 1'b0));
    check("R7 zero spacing", redirect_pc, 32'h9234_5200);
    irq_spacing = 5'd1;
    leave();
    begin
      vec_t v;
      v = mk(9'h001, 3'd0, 1'b0);
      v.boot = 1'b1;
      fire(v);
    end
    check("R7 boot vector", redirect_pc, 32'hBFC0_0400);
    irq_pending = 8'h00;
    leave();
    fire(mk(9'h001, 3'd0, 1'b0));
    check("R7 nothing pending", redirect_pc, 32'h9234_5280 - 32'h80);
    vec_irq_en = 1'b0;

    // R12 request beats leave in the same cycle
    @(negedge clk);
    exc_req = 9'h004; leave_exc = 1'b1;
    @(negedge clk);
    exc_req = '0; leave_exc = 1'b0;
    check("R12 request wins over leave", {31'd0, exc_level}, 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule